// File: doc/BRIEF.md
# Nested pulse violation detector

This block watches two level signals, an outer pulse and an inner pulse, and raises a sticky error flag when the inner pulse is not properly contained in the outer one. A legal exchange is: the outer line goes high, the inner line then goes high and later low, and only after that does the outer line drop. An outer pulse with no inner pulse at all is also legal. Everything else is a violation. Examples are an inner pulse with the outer line low, the outer line dropping while the inner one is still high, two lines rising in one sample, or a second inner pulse inside one outer pulse.

The detector is a synchronous Moore machine. It samples inputs that are already synchronized on every rising clock edge. The flag is a register that depends only on the machine state. Once raised, the flag stays high until a sample shows both lines low. Any sample with both lines low returns the machine to its idle state and clears the flag. This rule takes precedence over every other transition.

Top module: `nest_pulse_checker`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the machine goes to idle and `err_flag` reads 0 after that edge, whatever the inputs are.
- R2: A clock edge that samples `outer_in`=0 and `inner_in`=0 makes `err_flag` 0 after that edge, in every state.
- R3: A sample with `inner_in`=1 and `outer_in`=0 sets `err_flag` to 1 after that edge, in every state.
- R4: From idle, a sample in which both lines are already high (both changed in one sample) sets `err_flag`.
- R5: An outer pulse that contains no inner pulse (sample pattern 00, 10…10, 00) never sets `err_flag`.
- R6: A single inner pulse nested strictly inside the outer pulse (00, 10, 11…11, 10, 00) never sets `err_flag`.
- R7: The outer line dropping while the inner line is still high (11 followed by 01) sets `err_flag`.
- R8: A second inner pulse within the same outer pulse (…11, 10, 11) sets `err_flag` on the sample where the inner line rises again.
- R9: Once set, `err_flag` stays 1 for as long as at least one input is sampled high, including the legal-looking patterns 10 and 11.
- R10: `err_flag` changes on the same rising edge that samples the violating or clearing input pair, so it is visible one clock after the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| outer_in | input | 1 | Synchronized outer pulse level |
| inner_in | input | 1 | Synchronized inner pulse level |
| err_flag | output | 1 | Registered sticky violation flag |

## Verification
The hardest case to reach from the ports is the second inner pulse inside one outer pulse. It needs four samples in a specific order: the outer line rises, the inner line rises, the inner line falls, and the inner line rises again, all while the outer line stays high. A random walk seldom reaches that order before some other event ends or spoils the pulse. The stimulus therefore has a directed sequence for it. The random walk is also biased so that it usually changes only one line per step and tends to keep the outer line high, which makes the tail state and its re-entry occur often.

// File: rtl/nest_pkg.sv
package nest_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OUTER = 3'd1,
        ST_BOTH  = 3'd2,
        ST_TAIL  = 3'd3,
        ST_FAULT = 3'd4
    } nest_state_e;

    typedef struct packed {
        logic outer;
        logic inner;
    } pair_t;

    // Next state for one sampled pair; an all-low sample always wins.
    function automatic nest_state_e nest_step(nest_state_e cur, pair_t p);
        nest_state_e nxt;
        if (!p.outer && !p.inner) begin
            nxt = ST_IDLE;
        end else if (!p.outer) begin
            nxt = ST_FAULT;
        end else begin
            unique case (cur)
                ST_IDLE:  nxt = p.inner ? ST_FAULT : ST_OUTER;
                ST_OUTER: nxt = p.inner ? ST_BOTH  : ST_OUTER;
                ST_BOTH:  nxt = p.inner ? ST_BOTH  : ST_TAIL;
                ST_TAIL:  nxt = p.inner ? ST_FAULT : ST_TAIL;
                default:  nxt = ST_FAULT;
            endcase
        end
        return nxt;
    endfunction

    function automatic logic is_fault(nest_state_e s);
        return s == ST_FAULT;
    endfunction

endpackage

// File: rtl/nest_next_state.sv
module nest_next_state
    import nest_pkg::*;
(
    input  nest_state_e cur_state,
    input  pair_t       sample,
    output nest_state_e nxt_state
);
    always_comb begin
        nxt_state = nest_step(cur_state, sample);
    end
endmodule

// File: rtl/nest_state_hold.sv
module nest_state_hold
    import nest_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  nest_state_e nxt_state,
    output nest_state_e cur_state,
    output logic        flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= ST_IDLE;
            flag_q    <= 1'b0;
        end else begin
            cur_state <= nxt_state;
            flag_q    <= is_fault(nxt_state);
        end
    end
endmodule

// File: rtl/nest_pulse_checker.sv
module nest_pulse_checker
    import nest_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic outer_in,
    input  logic inner_in,
    output logic err_flag
);
    pair_t       sample;
    nest_state_e cur_state;
    nest_state_e nxt_state;

    assign sample.outer = outer_in;
    assign sample.inner = inner_in;

    nest_next_state u_next (
        .cur_state (cur_state),
        .sample    (sample),
        .nxt_state (nxt_state)
    );

    nest_state_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (nxt_state),
        .cur_state (cur_state),
        .flag_q    (err_flag)
    );

    // R2: an all-low sample clears the flag on that edge
    a_r2_idle_clears: assert property (@(posedge clk) disable iff (rst)
        (!outer_in && !inner_in) |=> !err_flag);

    // R3: inner high with outer low is always a violation
    a_r3_inner_alone: assert property (@(posedge clk) disable iff (rst)
        (inner_in && !outer_in) |=> err_flag);

    // R9: flag is sticky while any line stays high
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag && (outer_in || inner_in)) |=> err_flag);

    // R5: outer-only samples never raise a clear flag
    a_r5_outer_only_safe: assert property (@(posedge clk) disable iff (rst)
        (outer_in && !inner_in && !err_flag) |=> !err_flag);

    // R10: the flag only rises on an edge that saw a non-idle pair
    a_r10_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> ($past(outer_in) || $past(inner_in)));
endmodule

// File: tb/nest_pulse_checker_bench.sv
module nest_pulse_checker_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic outer_in = 1'b0;
    logic inner_in = 1'b0;
    logic err_flag;

    int checks = 0;
    int fails  = 0;
    int mstate = 0; // 0 idle, 1 outer seen, 2 inner inside, 3 inner finished, 9 error
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    nest_pulse_checker u_nest_pulse_checker (
        .clk      (clk),
        .rst      (rst),
        .outer_in (outer_in),
        .inner_in (inner_in),
        .err_flag (err_flag)
    );

    // Reference behaviour written from the requirements.
    function automatic int ref_next(int s, bit o, bit i);
        if (o == 1'b0 && i == 1'b0) return 0;
        if (s == 9) return 9;
        if (o == 1'b0) return 9;                 // inner alone or outer fell under inner
        if (s == 0) return (i ? 9 : 1);          // both rising together is illegal
        if (s == 1) return (i ? 2 : 1);
        if (s == 2) return (i ? 2 : 3);
        return (i ? 9 : 3);                      // second inner pulse is illegal
    endfunction

    task automatic check(input string tag);
        bit exp;
        exp = (mstate == 9);
        checks++;
        if (err_flag !== exp) begin
            fails++;
            $display("FAIL %s: err_flag=%b expected=%b", tag, err_flag, exp);
        end
    endtask

    // Called at a falling edge: drive, then check at the next falling edge.
    task automatic step(input bit o, input bit i, input string tag);
        outer_in = o;
        inner_in = i;
        mstate = ref_next(mstate, o, i);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: expired=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit o;
        bit i;
        void'($urandom(32'd20240611));
        // R1: reset with illegal inputs applied
        outer_in = 1'b1;
        inner_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (err_flag !== 1'b0) begin
            fails++;
            $display("FAIL R1: err_flag=%b expected=0", err_flag);
        end
        outer_in = 1'b0;
        inner_in = 1'b0;
        rst = 1'b0;
        mstate = 0;
        @(negedge clk);
        check("R1");

        // R5: outer pulse without inner pulse
        step(1, 0, "R5"); step(1, 0, "R5"); step(1, 0, "R5"); step(0, 0, "R5");
        // R6: one nested inner pulse
        step(1, 0, "R6"); step(1, 1, "R6"); step(1, 1, "R6");
        step(1, 0, "R6"); step(0, 0, "R6");
        // R3 and R10: inner alone, flag visible one clock later
        step(0, 1, "R3_R10"); step(0, 1, "R9"); step(0, 0, "R2");
        // R4: both lines rise in one sample
        step(1, 1, "R4"); step(1, 0, "R9"); step(1, 1, "R9"); step(0, 0, "R2");
        // R7: outer drops while inner is still high
        step(1, 0, "R7"); step(1, 1, "R7"); step(0, 1, "R7"); step(0, 0, "R2");
        // R8: second inner pulse inside one outer pulse
        step(1, 0, "R8"); step(1, 1, "R8"); step(1, 0, "R8");
        step(1, 1, "R8"); step(1, 0, "R9"); step(0, 0, "R2");
        // R3 from the tail state
        step(1, 0, "R3"); step(1, 1, "R3"); step(1, 0, "R3"); step(0, 1, "R3");
        step(0, 0, "R2");

        // Random walk biased to single-line changes and a high outer line
        o = 1'b0;
        i = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 45)       i = ~i;
            else if (r < 60)  o = ~o;
            else if (r < 68)  begin o = ~o; i = ~i; end
            else if (r < 75)  o = 1'b1;
            step(o, i, "R2_R3_R9_random");
        end
        step(0, 0, "R2");

        // R1: reset in the middle of a fault
        step(0, 1, "R3");
        rst = 1'b1;
        outer_in = 1'b1;
        @(negedge clk);
        checks++;
        if (err_flag !== 1'b0) begin
            fails++;
            $display("FAIL R1: err_flag=%b expected=0", err_flag);
        end
        rst = 1'b0;
        mstate = 1;
        inner_in = 1'b0;
        outer_in = 1'b1;
        @(negedge clk);
        check("R1");
        step(1, 1, "R6"); step(1, 0, "R6"); step(0, 0, "R6");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule